// File: doc/BRIEF.md
# Standby Wakeup Source Controller

This block decides when a chip in a light standby state should be woken. Each functional unit that can wake the chip has one raw event line. An event always sets that unit's bit in a sticky status register, whether or not the unit may wake the chip. A wake-enable mask selects which units may wake the chip. While the chip is in standby, any status bit that is also enabled raises a wake request to the power manager.

Software reaches the block through a small register bus. It can also arm or disarm a unit by naming an interrupt line on a set/clear port. Interrupt lines fold into enable bits through a fixed many-to-one map: the first two lines, which belong to two host-side USB controllers, share one enable bit. Every later line owns a bit of its own.

A standby request is refused while the enable mask is empty. On entry, a second enable register that belongs to a deeper power domain is forced to zero. When the power manager acknowledges the wake, both enable registers are cleared.

Top module: `wkup_ctrl`

## Requirements
- R1: After reset, the enable register (address 0), the status register (address 1), the deep-domain enable register (address 2) and the state register (address 3) all read zero, and `wake_o` is low.
- R2: An event on `evt_i[u]` sets status bit u on the next clock edge, whatever enable bit u holds. The bit stays set until it is cleared, and an event wins over a clear of the same bit in the same cycle.
- R3: A bus write to address 1 clears exactly those status bits whose write-data bit is 1. Bits written as 0 keep their value.
- R4: Interrupt line 0 and line 1 both select enable bit 0. Line i, for i >= 2, selects enable bit i-1.
- R5: A pulse on `irq_en_set` sets only the enable bit that `irq_sel` maps to, and a pulse on `irq_en_clr` clears only that bit. Every other bit is unchanged. When both are pulsed in the same cycle, the clear wins.
- R6: A bus write to address 0 replaces the whole enable register, and a read of address 0 returns it.
- R7: A `stby_req` pulse while the enable register is all zero is ignored: state bit 0 (the in-standby flag) stays 0.
- R8: A `stby_req` pulse with a nonzero enable register sets state bit 0 on the next edge and forces the deep-domain enable register to zero. Bus writes to that register while in standby have no effect. Outside standby, the register reads back what was written.
- R9: In standby, `wake_o` (also state bit 1) rises one cycle after status AND enable first becomes nonzero. It stays low outside standby, and it stays low for events on units that are not enabled.
- R10: `wake_ack` while in standby clears the in-standby flag, `wake_o`, the enable register and the deep-domain enable register on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Register address: 0 enable, 1 status, 2 deep enable, 3 state |
| wr | input | 1 | Write strobe for the addressed register |
| wdata | input | NUM_UNIT | Write data |
| rdata | output | NUM_UNIT | Read data of the addressed register, combinational |
| evt_i | input | NUM_UNIT | Raw wake events, one per functional unit |
| irq_sel | input | IRQ_W | Interrupt line index for the set/clear port |
| irq_en_set | input | 1 | Set the enable bit that `irq_sel` maps to |
| irq_en_clr | input | 1 | Clear the enable bit that `irq_sel` maps to |
| stby_req | input | 1 | Request standby entry |
| wake_ack | input | 1 | Power manager acknowledges the wake and leaves standby |
| wake_o | output | 1 | Wake request to the power manager |

## Verification
Register writes, set/clear pulses, standby entry and exit, and status capture each show one edge after the stimulus. The bench drives on a falling edge and reads `rdata` or `wake_o` at the next falling edge. `wake_o` sits two registers behind an event: status, then the wake flop. The bench therefore checks that it is still low one falling edge after the event and high at the second. It also checks that `wake_o` rises at the second edge after entry when an enabled event is already pending. Sweeps cover every interrupt line and every pair of enabled unit and firing unit.

// File: rtl/wkup_pkg.sv
// Shared definitions for the standby wakeup controller.
// Holds the register address map and the interrupt-to-unit folding rule.
package wkup_pkg;

    // Number of leading interrupt lines that fold onto enable bit 0.
    localparam int unsigned SHARED_IRQS = 2;

    typedef enum logic [1:0] {
        REG_ENABLE = 2'd0,
        REG_STATUS = 2'd1,
        REG_DEEP   = 2'd2,
        REG_STATE  = 2'd3
    } reg_addr_e;

    // Enable bit selected by interrupt line irq.
    function automatic int unsigned irq_to_unit(input int unsigned irq);
        if (irq < SHARED_IRQS) return 0;
        return irq - SHARED_IRQS + 1;
    endfunction

endpackage

// File: rtl/wkup_irq_map.sv
// Folds an interrupt line index into a one-hot enable-bit mask.
// Assumes NUM_UNIT = NUM_IRQ - SHARED_IRQS + 1. An index beyond NUM_IRQ gives an empty mask.
module wkup_irq_map #(
    parameter int unsigned NUM_IRQ  = 8,
    parameter int unsigned NUM_UNIT = 7,
    parameter int unsigned IRQ_W    = 3
) (
    input  logic [IRQ_W-1:0]    irq_sel,
    output logic [NUM_UNIT-1:0] unit_mask
);
    import wkup_pkg::*;

    logic [NUM_UNIT-1:0] rows [NUM_IRQ];

    // One constant row per interrupt line.
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_row
        assign rows[g] = NUM_UNIT'(1) << irq_to_unit(g);
    end

    // Select the row of the named line.
    always_comb begin
        unit_mask = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (irq_sel == IRQ_W'(i)) unit_mask = rows[i];
        end
    end

    // R4: a line never names more than one enable bit.
    always_comb begin
        p_map_onehot_r4: assert ($onehot0(unit_mask));
    end

endmodule

// File: rtl/wkup_status.sv
// Sticky wake status register, one bit per functional unit.
// Events set bits whatever the enable mask holds. Write-one clears, and an event beats a clear.
module wkup_status #(
    parameter int unsigned NUM_UNIT = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_UNIT-1:0] evt_i,
    input  logic [NUM_UNIT-1:0] clr_mask,
    output logic [NUM_UNIT-1:0] status
);

    // Capture events and apply write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_mask) | evt_i;
    end

    // R2: every event bit is present in status on the next cycle.
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((status & $past(evt_i)) == $past(evt_i)));

    // R3: with no clear requested, no status bit drops.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask == '0) |=> ((status & $past(status)) == $past(status)));

endmodule

// File: rtl/wkup_enable.sv
// Wake-enable mask for the standby domain.
// A bus write replaces the mask, then set and clear masks apply, with clear winning.
// Wipe (leaving standby) zeroes the mask ahead of everything else.
module wkup_enable #(
    parameter int unsigned NUM_UNIT = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [NUM_UNIT-1:0] bus_wdata,
    input  logic [NUM_UNIT-1:0] set_mask,
    input  logic [NUM_UNIT-1:0] clr_mask,
    input  logic                wipe,
    output logic [NUM_UNIT-1:0] en
);

    logic [NUM_UNIT-1:0] base;

    // Choose the bus value or the held value as the starting point.
    always_comb base = bus_we ? bus_wdata : en;

    // Update the mask.
    always_ff @(posedge clk) begin
        if (!rst_n)    en <= '0;
        else if (wipe) en <= '0;
        else           en <= (base | set_mask) & ~clr_mask;
    end

    // R5: a set/clear touches only its own bit.
    p_setclr_other_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we && !wipe && ((set_mask | clr_mask) != '0))
        |=> (((en ^ $past(en)) & ~$past(set_mask | clr_mask)) == '0));

    // R10: a wipe leaves an empty mask.
    p_wipe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (en == '0));

endmodule

// File: rtl/wkup_standby_seq.sv
// Standby entry/exit sequencing, wake request flop and deep-domain enable register.
// Entry needs a nonzero enable mask. Exit happens on the power manager's acknowledge.
module wkup_standby_seq #(
    parameter int unsigned NUM_UNIT = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stby_req,
    input  logic                wake_ack,
    input  logic                en_any,
    input  logic                pending,
    input  logic                deep_we,
    input  logic [NUM_UNIT-1:0] deep_wdata,
    output logic                in_stby,
    output logic                wake_o,
    output logic                wipe,
    output logic [NUM_UNIT-1:0] deep_en
);

    logic enter;

    // Entry and exit conditions.
    always_comb begin
        enter = stby_req && !in_stby && en_any;
        wipe  = in_stby && wake_ack;
    end

    // Standby flag.
    always_ff @(posedge clk) begin
        if (!rst_n)     in_stby <= 1'b0;
        else if (enter) in_stby <= 1'b1;
        else if (wipe)  in_stby <= 1'b0;
    end

    // Wake request: registered view of an enabled pending source in standby.
    always_ff @(posedge clk) begin
        if (!rst_n)    wake_o <= 1'b0;
        else if (wipe) wake_o <= 1'b0;
        else           wake_o <= in_stby && pending;
    end

    // Deep-domain enable: zero through standby, writable outside it.
    always_ff @(posedge clk) begin
        if (!rst_n)                              deep_en <= '0;
        else if (enter || in_stby)               deep_en <= '0;
        else if (deep_we)                        deep_en <= deep_wdata;
    end

    // R7: no entry with an empty mask.
    p_no_entry_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_stby && !en_any) |=> !in_stby);

    // R8: the deep-domain mask is zero throughout standby.
    p_deep_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_stby |-> (deep_en == '0));

    // R9: wake follows an enabled pending source by one cycle.
    p_wake_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stby && pending && !wake_ack) |=> wake_o);

    // R9: no wake outside standby.
    p_wake_in_stby_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> in_stby);

    // R10: acknowledge leaves standby with the request dropped.
    p_exit_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stby && wake_ack) |=> (!in_stby && !wake_o));

endmodule

// File: rtl/wkup_ctrl.sv
// Standby wakeup controller top.
// Decodes the register bus, folds interrupt-line set/clear requests onto enable bits,
// and ties the status, enable and sequencing blocks together.
// Assumes NUM_UNIT >= 2 so that the state register fits on the data bus.
module wkup_ctrl #(
    parameter int unsigned NUM_IRQ  = 8,
    parameter int unsigned NUM_UNIT = NUM_IRQ - wkup_pkg::SHARED_IRQS + 1,
    parameter int unsigned IRQ_W    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          addr,
    input  logic                wr,
    input  logic [NUM_UNIT-1:0] wdata,
    output logic [NUM_UNIT-1:0] rdata,
    input  logic [NUM_UNIT-1:0] evt_i,
    input  logic [IRQ_W-1:0]    irq_sel,
    input  logic                irq_en_set,
    input  logic                irq_en_clr,
    input  logic                stby_req,
    input  logic                wake_ack,
    output logic                wake_o
);
    import wkup_pkg::*;

    logic [NUM_UNIT-1:0] line_mask, set_mask, clr_mask, st_clr;
    logic [NUM_UNIT-1:0] status, en, deep_en;
    logic                en_we, deep_we, in_stby, wipe, pending;

    // Bus write decode and set/clear gating.
    always_comb begin
        en_we    = wr && (addr == REG_ENABLE);
        deep_we  = wr && (addr == REG_DEEP);
        st_clr   = (wr && (addr == REG_STATUS)) ? wdata : '0;
        set_mask = irq_en_set ? line_mask : '0;
        clr_mask = irq_en_clr ? line_mask : '0;
        pending  = (status & en) != '0;
    end

    wkup_irq_map #(.NUM_IRQ(NUM_IRQ), .NUM_UNIT(NUM_UNIT), .IRQ_W(IRQ_W)) u_map (
        .irq_sel   (irq_sel),
        .unit_mask (line_mask)
    );

    wkup_status #(.NUM_UNIT(NUM_UNIT)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .clr_mask (st_clr),
        .status   (status)
    );

    wkup_enable #(.NUM_UNIT(NUM_UNIT)) u_enable (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (en_we),
        .bus_wdata (wdata),
        .set_mask  (set_mask),
        .clr_mask  (clr_mask),
        .wipe      (wipe),
        .en        (en)
    );

    wkup_standby_seq #(.NUM_UNIT(NUM_UNIT)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .stby_req   (stby_req),
        .wake_ack   (wake_ack),
        .en_any     (en != '0),
        .pending    (pending),
        .deep_we    (deep_we),
        .deep_wdata (wdata),
        .in_stby    (in_stby),
        .wake_o     (wake_o),
        .wipe       (wipe),
        .deep_en    (deep_en)
    );

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            REG_ENABLE: rdata = en;
            REG_STATUS: rdata = status;
            REG_DEEP:   rdata = deep_en;
            default: begin
                rdata[0] = in_stby;
                rdata[1] = wake_o;
            end
        endcase
    end

endmodule

// File: tb/wkup_ctrl_tb.sv
// Self-checking bench for wkup_ctrl with 8 interrupt lines and 7 units.
module wkup_ctrl_tb;
    localparam int NI = 8;
    localparam int NU = 7;
    localparam int IW = 3;
    localparam logic [NU-1:0] ALL = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    addr = '0;
    logic          wr = 1'b0;
    logic [NU-1:0] wdata = '0;
    logic [NU-1:0] rdata;
    logic [NU-1:0] evt_i = '0;
    logic [IW-1:0] irq_sel = '0;
    logic          irq_en_set = 1'b0;
    logic          irq_en_clr = 1'b0;
    logic          stby_req = 1'b0;
    logic          wake_ack = 1'b0;
    logic          wake_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    wkup_ctrl #(.NUM_IRQ(NI)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .wdata(wdata), .rdata(rdata),
        .evt_i(evt_i), .irq_sel(irq_sel), .irq_en_set(irq_en_set), .irq_en_clr(irq_en_clr),
        .stby_req(stby_req), .wake_ack(wake_ack), .wake_o(wake_o)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [NU-1:0] d);
        addr = a; wdata = d; wr = 1'b1;
        tick();
        wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input int exp);
        addr = a;
        #1;
        chk(tag, int'(rdata), exp);
    endtask

    function automatic int unit_of(input int irq);
        return (irq < 2) ? 0 : irq - 1;
    endfunction

    task automatic enter_stby();
        stby_req = 1'b1;
        tick();
        stby_req = 1'b0;
    endtask

    task automatic ack();
        wake_ack = 1'b1;
        tick();
        wake_ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual expired expected done");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        rd_chk("R1 enable", 2'd0, 0);
        rd_chk("R1 status", 2'd1, 0);
        rd_chk("R1 deep", 2'd2, 0);
        rd_chk("R1 state", 2'd3, 0);
        chk("R1 wake_o", int'(wake_o), 0);

        // R6: whole-register writes
        for (int p = 0; p < 128; p++) begin
            wr_reg(2'd0, NU'(p));
            rd_chk("R6 enable readback", 2'd0, p);
        end

        // R4 / R5: set and clear through every line
        for (int i = 0; i < NI; i++) begin
            wr_reg(2'd0, '0);
            irq_sel = IW'(i); irq_en_set = 1'b1;
            tick();
            irq_en_set = 1'b0;
            rd_chk("R4 set maps line", 2'd0, 1 << unit_of(i));
            wr_reg(2'd0, ALL);
            irq_en_clr = 1'b1;
            tick();
            irq_en_clr = 1'b0;
            rd_chk("R5 clear touches one bit", 2'd0, int'(ALL) & ~(1 << unit_of(i)));
            wr_reg(2'd0, 7'h2A);
            irq_en_set = 1'b1; irq_en_clr = 1'b1;
            tick();
            irq_en_set = 1'b0; irq_en_clr = 1'b0;
            rd_chk("R5 clear beats set", 2'd0, 'h2A & ~(1 << unit_of(i)));
        end

        // R2 / R3: status capture and write-one-to-clear
        wr_reg(2'd0, '0);
        for (int u = 0; u < NU; u++) begin
            wr_reg(2'd1, ALL);
            evt_i = NU'(1 << u);
            tick();
            evt_i = '0;
            rd_chk("R2 event sets with enable off", 2'd1, 1 << u);
            wr_reg(2'd1, ~NU'(1 << u));
            rd_chk("R3 zero bits keep status", 2'd1, 1 << u);
            wr_reg(2'd1, NU'(1 << u));
            rd_chk("R3 one bit clears", 2'd1, 0);
            evt_i = NU'(1 << u);
            wr_reg(2'd1, NU'(1 << u));
            evt_i = '0;
            rd_chk("R2 event beats clear", 2'd1, 1 << u);
        end
        wr_reg(2'd1, ALL);

        // R7: empty mask refuses entry
        wr_reg(2'd0, '0);
        enter_stby();
        rd_chk("R7 no entry", 2'd3, 0);

        // R8: deep-domain register
        wr_reg(2'd2, 7'h55);
        rd_chk("R8 deep readback", 2'd2, 'h55);
        wr_reg(2'd0, 7'h01);
        enter_stby();
        rd_chk("R8 entered", 2'd3, 1);
        rd_chk("R8 deep forced zero", 2'd2, 0);
        wr_reg(2'd2, 7'h2A);
        rd_chk("R8 deep write ignored", 2'd2, 0);
        ack();
        rd_chk("R10 state after ack", 2'd3, 0);

        // R9: event outside standby does not wake
        wr_reg(2'd0, ALL);
        evt_i = 7'h01;
        tick();
        evt_i = '0;
        tick();
        chk("R9 no wake outside standby", int'(wake_o), 0);
        // R9: pending at entry wakes one cycle after entry
        enter_stby();
        chk("R9 not yet at entry", int'(wake_o), 0);
        tick();
        chk("R9 pending at entry", int'(wake_o), 1);
        ack();

        // R9 / R10: every enabled unit against every firing unit
        for (int u = 0; u < NU; u++) begin
            for (int v = 0; v < NU; v++) begin
                wr_reg(2'd1, ALL);
                wr_reg(2'd0, NU'(1 << u));
                enter_stby();
                rd_chk("R8 entered in sweep", 2'd3, 1);
                evt_i = NU'(1 << v);
                tick();
                evt_i = '0;
                chk("R9 no wake one cycle after event", int'(wake_o), 0);
                tick();
                chk("R9 wake only when enabled", int'(wake_o), (u == v) ? 1 : 0);
                ack();
                chk("R10 wake drops", int'(wake_o), 0);
                rd_chk("R10 standby left", 2'd3, 0);
                rd_chk("R10 enable cleared", 2'd0, 0);
                rd_chk("R10 deep cleared", 2'd2, 0);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule